// File: doc/BRIEF.md
# Timer Input Capture Unit

The unit watches one external input pin and copies the value of a free-running 16-bit timer into a holding register when a chosen event occurs on that pin. The pin is synchronised to the clock before any edge is detected. An event is either a single edge, falling or rising, or every 4th or every 16th rising edge. For the last two, a small prescaler counts the rising edges.

Each capture raises a sticky interrupt flag, and software clears that flag with a one-cycle strobe. The prescaler is zeroed whenever the unit is disabled or its mode field is not a capture mode. It keeps its count when software moves directly from one capture mode to another. Such a direct move also raises the flag even though no event took place. Software is expected to go through the off mode when it changes settings, and to clear the flag afterwards.

Top module: `cap_unit`

## Requirements
- R1: A qualified event loads the full 16-bit timer value into `cap_val`. The pin passes two synchronising flops and one edge-history flop. `cap_val` therefore shows the timer value sampled at the third rising clock edge after the pin changes, and is unchanged after only two edges.
- R2: Mode 4'b0100 captures on every falling edge of the pin. A rising edge in this mode captures nothing.
- R3: Mode 4'b0101 captures on every rising edge of the pin. A falling edge in this mode captures nothing.
- R4: Mode 4'b0110 captures on every 4th rising edge, and mode 4'b0111 on every 16th rising edge. Counting starts from a cleared prescaler. Rising edges that fall short of the count capture nothing.
- R5: Every capture sets `flag`. The flag stays set until `flag_clr` is high for a clock cycle. If a clear strobe and a capture happen in the same cycle, the flag ends up set.
- R6: A new capture overwrites `cap_val` even when the earlier value has not been read.
- R7: While `en` is low, or while `mode[3:2]` is not 2'b01 (for example 4'b0000 for off, or 4'b1101), there is no capture and no flag change, and the prescaler count is cleared. After re-enabling, the full 4 or 16 rising edges are needed again.
- R8: A direct change from one capture mode to a different capture mode while enabled sets `flag` without loading `cap_val`. The prescaler count survives the change. For example, 7 rising edges in mode 4'b0111 followed by a switch to 4'b0110 make the next rising edge capture.
- R9: After reset, `cap_val` is 0 and `flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable |
| mode | input | 4 | Event selection (01xx = capture modes) |
| pin_raw | input | 1 | Unsynchronised capture pin |
| tmr_val | input | 16 | Free-running timer value |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| cap_val | output | 16 | Held captured timer value |
| flag | output | 1 | Sticky capture interrupt flag |

## Verification
The assertions take for granted that `tmr_val` is synchronous to `clk`. They also assume that `pin_raw` is low when reset ends, so the synchroniser does not report a false rising edge. The stimulus holds the pin low through reset, and drives the pin, the timer value, the mode and the clear strobe only on falling clock edges. Each pin level is held for four cycles, so every edge reaches the detector as a clean single-cycle pulse. The timer value is held steady across the whole capture window, which makes the expected captured value unambiguous.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_FALL   = 4'b0100;
  localparam logic [MODE_W-1:0] MODE_RISE   = 4'b0101;
  localparam logic [MODE_W-1:0] MODE_RISE4  = 4'b0110;
  localparam logic [MODE_W-1:0] MODE_RISE16 = 4'b0111;
  localparam int PRE_W = 4;

  function automatic logic is_capture(input logic [MODE_W-1:0] m);
    return m[3:2] == 2'b01;
  endfunction

  // terminal count reached for the selected divide ratio
  function automatic logic pre_fire(input logic [PRE_W-1:0] cnt, input logic div4);
    return div4 ? (cnt[1:0] == 2'b11) : (cnt == {PRE_W{1'b1}});
  endfunction

  function automatic logic [PRE_W-1:0] pre_next(input logic [PRE_W-1:0] cnt, input logic fire);
    return fire ? '0 : cnt + 1'b1;
  endfunction
endpackage

// File: rtl/cap_edge.sv
module cap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_raw};
      hist_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~hist_q;
  assign fall = ~sync_q[STAGES-1] & hist_q;

  assert_edge_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
  assert_rise_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/cap_prescale.sv
module cap_prescale
  import cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic div4,
  input  logic div16,
  input  logic rise,
  output logic fire
);
  logic [PRE_W-1:0] cnt_q;
  logic             counting;

  assign counting = act & (div4 | div16);
  assign fire     = counting & rise & pre_fire(cnt_q, div4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!act)            cnt_q <= '0;
    else if (counting && rise) cnt_q <= pre_next(cnt_q, fire);
  end

  assert_clear_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> cnt_q == '0);
  assert_fire_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> rise && act);
  assert_restart_after_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt_q == '0);
endmodule

// File: rtl/cap_hold.sv
module cap_hold #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          spur,
  input  logic          clr,
  input  logic [TW-1:0] tmr,
  output logic [TW-1:0] val,
  output logic          flag
);
  logic set_flag;
  assign set_flag = take | spur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val  <= '0;
      flag <= 1'b0;
    end else begin
      if (take) val <= tmr;
      if (set_flag)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
    end
  end

  assert_load_timer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> val == $past(tmr));
  assert_flag_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> flag);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
  assert_flag_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set_flag |=> !flag);
  assert_hold_without_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(val));
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic              pin_raw,
  input  logic [TW-1:0]     tmr_val,
  input  logic              flag_clr,
  output logic [TW-1:0]     cap_val,
  output logic              flag
);
  logic              rise, fall, fire;
  logic              act, act_q, take, spur;
  logic [MODE_W-1:0] mode_q;

  assign act = en & is_capture(mode);

  cap_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .rise(rise), .fall(fall));

  cap_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .act(act),
    .div4(mode == MODE_RISE4), .div16(mode == MODE_RISE16),
    .rise(rise), .fire(fire));

  assign take = act & ((fall & (mode == MODE_FALL)) |
                       (rise & (mode == MODE_RISE)) | fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      act_q  <= act;
      mode_q <= mode;
    end
  end

  // direct move between two capture modes
  assign spur = act & act_q & (mode != mode_q);

  cap_hold #(.TW(TW)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(take), .spur(spur), .clr(flag_clr),
    .tmr(tmr_val), .val(cap_val), .flag(flag));

  assert_idle_no_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> $stable(cap_val));
  assert_spur_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spur && !take |=> $stable(cap_val) && flag);
  assert_idle_flag_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !act && !flag_clr |=> flag == $past(flag));
endmodule

// File: tb/sim_cap_unit.sv
module sim_cap_unit;
  logic        clk = 0;
  logic        rst_n, en, pin_raw, flag_clr;
  logic [3:0]  mode;
  logic [15:0] tmr_val, cap_val;
  logic        flag;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cap_unit u0 (.clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .pin_raw(pin_raw),
               .tmr_val(tmr_val), .flag_clr(flag_clr), .cap_val(cap_val), .flag(flag));

  // {mode, rising pulses, timer base, expected cap_val, expected flag}
  localparam logic [41:0] VEC [8] = '{
    {4'b0101, 5'd3,  16'h1000, 16'h1002, 1'b1},   // R3 R6
    {4'b0100, 5'd2,  16'h2000, 16'h2001, 1'b1},   // R2
    {4'b0110, 5'd4,  16'h3000, 16'h3003, 1'b1},   // R4
    {4'b0110, 5'd7,  16'h3100, 16'h3103, 1'b1},   // R4
    {4'b0111, 5'd16, 16'h4000, 16'h400F, 1'b1},   // R4
    {4'b0111, 5'd15, 16'h5000, 16'h400F, 1'b0},   // R4
    {4'b0110, 5'd3,  16'h6000, 16'h400F, 1'b0},   // R4
    {4'b0101, 5'd1,  16'hFFFF, 16'hFFFF, 1'b1}    // R1
  };

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    pin_raw = 1'b1; step(4);
    pin_raw = 1'b0; step(4);
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  task automatic set_mode(logic [3:0] m);
    mode = 4'b0000; step(2); mode = m; step(2);
  endtask

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0]  vm;
    logic [4:0]  vn;
    logic [15:0] vb, vc;
    logic        vf;
    rst_n = 0; en = 0; pin_raw = 0; flag_clr = 0; mode = 0; tmr_val = 0;
    step(3); rst_n = 1; step(1);
    check("R9 cap", cap_val, 16'h0);
    check("R9 flag", {15'b0, flag}, 16'h0);

    en = 1;
    for (int v = 0; v < 8; v++) begin
      {vm, vn, vb, vc, vf} = VEC[v];
      set_mode(vm); clear_flag();
      for (int i = 0; i < int'(vn); i++) begin
        tmr_val = vb + 16'(i);
        pulse();
      end
      step(4);
      check($sformatf("R4 vec%0d cap", v), cap_val, vc);
      check($sformatf("R5 vec%0d flag", v), {15'b0, flag}, {15'b0, vf});
    end

    // R1 latency through synchroniser
    set_mode(4'b0101); clear_flag();
    tmr_val = 16'hAAAA; pin_raw = 1; step(2);
    check("R1 early cap", cap_val, 16'hFFFF);
    check("R1 early flag", {15'b0, flag}, 16'h0);
    step(1);
    check("R1 cap", cap_val, 16'hAAAA);
    pin_raw = 0; step(4);

    // R3 rising only
    tmr_val = 16'h1111; pin_raw = 1; step(4);
    tmr_val = 16'h2222; pin_raw = 0; step(4);
    check("R3 rise only", cap_val, 16'h1111);

    // R2 falling only
    set_mode(4'b0100); clear_flag();
    tmr_val = 16'h3333; pin_raw = 1; step(4);
    check("R2 no rise flag", {15'b0, flag}, 16'h0);
    check("R2 no rise cap", cap_val, 16'h1111);
    tmr_val = 16'h4444; pin_raw = 0; step(4);
    check("R2 fall cap", cap_val, 16'h4444);

    // R5 sticky and clear
    step(10);
    check("R5 sticky", {15'b0, flag}, 16'h1);
    clear_flag(); step(1);
    check("R5 cleared", {15'b0, flag}, 16'h0);

    // R5 clear coincides with capture
    tmr_val = 16'h5555; pin_raw = 1; step(4);
    pin_raw = 0; step(2);
    flag_clr = 1; step(1); flag_clr = 0; step(1);
    check("R5 clr+capture flag", {15'b0, flag}, 16'h1);
    check("R5 clr+capture cap", cap_val, 16'h5555);

    // R7 disabled or non-capture mode
    clear_flag(); en = 0; set_mode(4'b0101);
    tmr_val = 16'h6666; pulse(); step(2);
    check("R7 en low flag", {15'b0, flag}, 16'h0);
    check("R7 en low cap", cap_val, 16'h5555);
    en = 1; mode = 4'b1101; step(2); clear_flag();
    pulse(); step(2);
    check("R7 mode 1101 flag", {15'b0, flag}, 16'h0);
    check("R7 mode 1101 cap", cap_val, 16'h5555);

    // R7 prescaler cleared by disable
    set_mode(4'b0110); clear_flag();
    tmr_val = 16'h7000;
    for (int i = 0; i < 3; i++) pulse();
    en = 0; step(2); en = 1; step(2);
    tmr_val = 16'h8888; pulse(); step(2);
    check("R7 prescale cleared flag", {15'b0, flag}, 16'h0);
    check("R7 prescale cleared cap", cap_val, 16'h5555);
    for (int i = 1; i < 4; i++) begin
      tmr_val = 16'h8888 + 16'(i);
      pulse();
    end
    step(2);
    check("R7 fourth after enable", cap_val, 16'h888B);

    // R8 direct switch between capture modes
    set_mode(4'b0111); clear_flag();
    for (int i = 0; i < 7; i++) begin
      tmr_val = 16'h9000 + 16'(i);
      pulse();
    end
    check("R4 x16 no early flag", {15'b0, flag}, 16'h0);
    mode = 4'b0110; step(2);
    check("R8 spurious flag", {15'b0, flag}, 16'h1);
    check("R8 no load", cap_val, 16'h888B);
    clear_flag();
    tmr_val = 16'h7777; pulse(); step(2);
    check("R8 early capture", cap_val, 16'h7777);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule